// File: doc/BRIEF.md
# Go-Back-N Sender with Link Failover

This block is the transmitting end of a reliable, in-order packet link. Packets offered by a user are given consecutive 4-bit sequence numbers, held in a small circular store, and sent in order to whichever physical link is currently selected. A receiver accepts only the packet it expects next and answers with cumulative acknowledgements. The sender frees acknowledged packets and restarts its timer on each one. When the timer runs out, it sends the whole outstanding window again, starting from the oldest packet.

Each link is given a fixed number of retransmission rounds. After that the sender moves to the next entry of a static route list, which is ordered by preference. Entries past the configured list length are skipped, and so is any entry naming the link the traffic came in on. When no entry is left, the outstanding packets are discarded and a failure pulse is raised. Success is reported per link, when that link acknowledges delivery. Framing, checksums and the links themselves sit outside this block and appear here as plain valid/ready packet ports.

Top module: `arq_link_sender`

## Requirements
- R1: After reset, accepted packets are numbered 0, 1, 2, ... modulo 16. Their first transmissions appear on txSeq/txData in acceptance order, with the data that was accepted.
- R2: inReady is high only while the number of outstanding packets is below the effective window. That window is cfgWindow clamped into 1..8: 0 acts as 1, and values above 8 act as 8.
- R3: An ack counts when the distance (ackSeq minus oldest outstanding sequence, modulo 16) is below the outstanding count. Such an ack frees the oldest packet through ackSeq. On the next cycle doneValid pulses, doneCount gives the number freed and doneLink gives the link in use.
- R4: An ack outside that range is ignored: no doneValid appears and the outstanding set stays as it was.
- R5: A timer runs while packets are outstanding and is restarted by every counted ack and every timeout. On timeout the next transmission is the oldest outstanding packet, and the rest follow in order. Repeated transmissions of an unacknowledged oldest packet come cfgTimeout+1 cycles apart.
- R6: On one link the oldest packet is sent 1+cfgRetries times. The next timeout moves transmission to the next usable route entry.
- R7: A route entry is usable when its index is below routeLen and its link differs from originLink. Entry j is routeTable[j*3 +: 3], and entry 0 is the most preferred. txLink never equals originLink. Whenever nothing is outstanding, the sender returns to the first usable entry.
- R8: A timeout with the retries spent and no later usable entry drops every outstanding packet. It also pulses failValid for one cycle, with failCount equal to the number dropped.
- R9: With no usable route entry, inReady and txValid stay low.
- R10: After reset, txValid, doneValid and failValid are low and inReady is high (given a usable entry).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWindow | input | 4 | Requested transmit window (clamped to 1..8) |
| cfgRetries | input | 3 | Retransmission rounds allowed per link |
| cfgTimeout | input | 8 | Timer limit in cycles (at least 1) |
| routeTable | input | 12 | Four 3-bit link ids, entry 0 in the low bits |
| routeLen | input | 3 | Number of valid route entries |
| originLink | input | 3 | Link the traffic arrived on, never used for sending |
| inValid | input | 1 | User offers a packet |
| inData | input | 8 | User packet payload |
| inReady | output | 1 | Sender accepts the offered packet |
| txValid | output | 1 | A packet is presented to the link |
| txReady | input | 1 | Link takes the presented packet |
| txSeq | output | 4 | Sequence number of the presented packet |
| txData | output | 8 | Payload of the presented packet |
| txLink | output | 3 | Link id currently selected |
| ackValid | input | 1 | Acknowledgement present |
| ackSeq | input | 4 | Highest sequence number acknowledged |
| doneValid | output | 1 | Pulse: packets acknowledged by a link |
| doneCount | output | 4 | Number of packets freed by that ack |
| doneLink | output | 3 | Link that acknowledged them |
| failValid | output | 1 | Pulse: route list exhausted, packets dropped |
| failCount | output | 4 | Number of packets dropped |

## Verification
The assertions assume three things. Acknowledgements only name sequence numbers that have actually gone out. The configuration inputs stay still while packets are outstanding. cfgTimeout is never zero. The random stimulus gets its acks from a receiver model that counts in-order deliveries and acks only what it has taken in, so an ack is always stale or in range. Configuration changes only across resets, and the timeout is set well above the receiver's ack latency, so recovery happens through retransmission and not through failover.

// File: rtl/arq_pkg.sv
package arq_pkg;
  // Control-to-datapath strobes
  typedef struct packed {
    logic rewind;  // send again from the oldest outstanding packet
    logic flush;   // drop every outstanding packet
  } ctrlStrobe_t;
endpackage

// File: rtl/arq_tx_datapath.sv
module arq_tx_datapath
  import arq_pkg::*;
#(
  parameter int MAX_WIN = 8,
  parameter int DATA_W  = 8,
  parameter int SEQ_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [SEQ_W-1:0]  cfgWindow,
  input  logic              linkUp,
  input  logic              routeOk,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              inReady,
  output logic              txValid,
  input  logic              txReady,
  output logic [SEQ_W-1:0]  txSeq,
  output logic [DATA_W-1:0] txData,
  input  logic              ackValid,
  input  logic [SEQ_W-1:0]  ackSeq,
  output logic              ackGood,
  output logic [SEQ_W-1:0]  ackFreed,
  output logic [SEQ_W-1:0]  outstanding
);
  localparam int PTR_W = SEQ_W - 1;

  logic [DATA_W-1:0] slotMem [MAX_WIN];
  logic [SEQ_W-1:0]  baseSeq, nextSeq, sendSeq, count;
  logic [SEQ_W-1:0]  winLimit, ackDist, sendAdv, cntAfter;
  logic              accept, fire;

  always_comb begin
    if (cfgWindow == '0)                       winLimit = SEQ_W'(1);
    else if (cfgWindow > SEQ_W'(MAX_WIN))      winLimit = SEQ_W'(MAX_WIN);
    else                                       winLimit = cfgWindow;
  end

  assign inReady     = routeOk && (count < winLimit);
  assign accept      = inValid && inReady;
  assign txValid     = linkUp && (sendSeq != nextSeq);
  assign fire        = txValid && txReady;
  assign txSeq       = sendSeq;
  assign txData      = slotMem[sendSeq[PTR_W-1:0]];
  assign outstanding = count;

  assign ackDist  = ackSeq - baseSeq;
  assign ackGood  = ackValid && (ackDist < count);
  assign ackFreed = ackDist + SEQ_W'(1);
  assign sendAdv  = sendSeq + SEQ_W'(fire);
  assign cntAfter = strobe.flush ? '0 : (ackGood ? count - ackFreed : count);

  always_ff @(posedge clk) begin
    if (accept) slotMem[nextSeq[PTR_W-1:0]] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseSeq <= '0;
      nextSeq <= '0;
      sendSeq <= '0;
      count   <= '0;
    end else begin
      count   <= cntAfter + SEQ_W'(accept);
      nextSeq <= nextSeq + SEQ_W'(accept);
      if (strobe.flush)  baseSeq <= nextSeq;
      else if (ackGood)  baseSeq <= ackSeq + SEQ_W'(1);
      if (strobe.flush)
        sendSeq <= nextSeq;
      else if (strobe.rewind)
        sendSeq <= baseSeq;
      else if (ackGood && ((sendAdv - baseSeq) < ackFreed))
        sendSeq <= ackSeq + SEQ_W'(1);
      else
        sendSeq <= sendAdv;
    end
  end
endmodule

// File: rtl/arq_tx_control.sv
module arq_tx_control
  import arq_pkg::*;
#(
  parameter int NUM_LINKS = 4,
  parameter int LINK_W    = 3,
  parameter int SEQ_W     = 4,
  parameter int RETRY_W   = 3,
  parameter int TMR_W     = 8,
  parameter int IDX_W     = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [RETRY_W-1:0]          cfgRetries,
  input  logic [TMR_W-1:0]            cfgTimeout,
  input  logic [NUM_LINKS*LINK_W-1:0] routeTable,
  input  logic [IDX_W:0]              routeLen,
  input  logic [LINK_W-1:0]           originLink,
  input  logic                        ackGood,
  input  logic [SEQ_W-1:0]            ackFreed,
  input  logic [SEQ_W-1:0]            outstanding,
  output ctrlStrobe_t                 strobe,
  output logic                        linkUp,
  output logic                        routeOk,
  output logic [LINK_W-1:0]           txLink,
  output logic                        doneValid,
  output logic [SEQ_W-1:0]            doneCount,
  output logic [LINK_W-1:0]           doneLink,
  output logic                        failValid,
  output logic [SEQ_W-1:0]            failCount
);
  logic [NUM_LINKS-1:0] entryUsable;
  logic [LINK_W-1:0]    entryLink [NUM_LINKS];
  logic [IDX_W-1:0]     routeIdx, firstIdx, nextIdx;
  logic                 firstOk, nextOk, timeout, idle;
  logic [TMR_W-1:0]     timer;
  logic [RETRY_W-1:0]   retryCnt;

  for (genvar g = 0; g < NUM_LINKS; g++) begin : g_entry
    assign entryLink[g]   = routeTable[g*LINK_W +: LINK_W];
    assign entryUsable[g] = ((IDX_W+1)'(g) < routeLen) && (entryLink[g] != originLink);
  end

  // lowest usable index overall, and lowest usable index after the active one
  always_comb begin
    firstOk  = 1'b0;
    firstIdx = '0;
    nextOk   = 1'b0;
    nextIdx  = '0;
    for (int j = NUM_LINKS - 1; j >= 0; j--) begin
      if (entryUsable[j]) begin
        firstOk  = 1'b1;
        firstIdx = IDX_W'(j);
        if (j > int'(routeIdx)) begin
          nextOk  = 1'b1;
          nextIdx = IDX_W'(j);
        end
      end
    end
  end

  assign idle    = (outstanding == '0);
  assign routeOk = firstOk;
  assign linkUp  = entryUsable[routeIdx];
  assign txLink  = entryLink[routeIdx];
  assign timeout = !idle && !ackGood && (timer >= cfgTimeout);

  always_comb begin
    strobe = '0;
    if (timeout) begin
      if (retryCnt < cfgRetries || nextOk) strobe.rewind = 1'b1;
      else                                 strobe.flush  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer     <= '0;
      retryCnt  <= '0;
      routeIdx  <= '0;
      doneValid <= 1'b0;
      doneCount <= '0;
      doneLink  <= '0;
      failValid <= 1'b0;
      failCount <= '0;
    end else begin
      if (idle || ackGood || timeout) timer <= '0;
      else                            timer <= timer + TMR_W'(1);

      if (idle || strobe.flush) begin
        routeIdx <= firstIdx;
        retryCnt <= '0;
      end else if (timeout) begin
        if (retryCnt < cfgRetries) begin
          retryCnt <= retryCnt + RETRY_W'(1);
        end else begin
          retryCnt <= '0;
          routeIdx <= nextIdx;
        end
      end else if (ackGood) begin
        retryCnt <= '0;
      end

      doneValid <= ackGood;
      doneCount <= ackGood ? ackFreed : '0;
      doneLink  <= ackGood ? txLink : '0;
      failValid <= strobe.flush;
      failCount <= strobe.flush ? outstanding : '0;
    end
  end
endmodule

// File: rtl/arq_link_sender.sv
module arq_link_sender
  import arq_pkg::*;
#(
  parameter int MAX_WIN   = 8,
  parameter int DATA_W    = 8,
  parameter int NUM_LINKS = 4,
  parameter int LINK_W    = 3,
  parameter int RETRY_W   = 3,
  parameter int TMR_W     = 8,
  localparam int SEQ_W    = $clog2(MAX_WIN) + 1,
  localparam int IDX_W    = $clog2(NUM_LINKS)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [SEQ_W-1:0]            cfgWindow,
  input  logic [RETRY_W-1:0]          cfgRetries,
  input  logic [TMR_W-1:0]            cfgTimeout,
  input  logic [NUM_LINKS*LINK_W-1:0] routeTable,
  input  logic [IDX_W:0]              routeLen,
  input  logic [LINK_W-1:0]           originLink,
  input  logic                        inValid,
  input  logic [DATA_W-1:0]           inData,
  output logic                        inReady,
  output logic                        txValid,
  input  logic                        txReady,
  output logic [SEQ_W-1:0]            txSeq,
  output logic [DATA_W-1:0]           txData,
  output logic [LINK_W-1:0]           txLink,
  input  logic                        ackValid,
  input  logic [SEQ_W-1:0]            ackSeq,
  output logic                        doneValid,
  output logic [SEQ_W-1:0]            doneCount,
  output logic [LINK_W-1:0]           doneLink,
  output logic                        failValid,
  output logic [SEQ_W-1:0]            failCount
);
  ctrlStrobe_t      strobe;
  logic             linkUp, routeOk, ackGood;
  logic [SEQ_W-1:0] ackFreed, outstanding;

  arq_tx_datapath #(.MAX_WIN(MAX_WIN), .DATA_W(DATA_W), .SEQ_W(SEQ_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgWindow(cfgWindow),
    .linkUp(linkUp), .routeOk(routeOk),
    .inValid(inValid), .inData(inData), .inReady(inReady),
    .txValid(txValid), .txReady(txReady), .txSeq(txSeq), .txData(txData),
    .ackValid(ackValid), .ackSeq(ackSeq),
    .ackGood(ackGood), .ackFreed(ackFreed), .outstanding(outstanding)
  );

  arq_tx_control #(.NUM_LINKS(NUM_LINKS), .LINK_W(LINK_W), .SEQ_W(SEQ_W),
                   .RETRY_W(RETRY_W), .TMR_W(TMR_W), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgRetries(cfgRetries), .cfgTimeout(cfgTimeout),
    .routeTable(routeTable), .routeLen(routeLen), .originLink(originLink),
    .ackGood(ackGood), .ackFreed(ackFreed), .outstanding(outstanding),
    .strobe(strobe), .linkUp(linkUp), .routeOk(routeOk), .txLink(txLink),
    .doneValid(doneValid), .doneCount(doneCount), .doneLink(doneLink),
    .failValid(failValid), .failCount(failCount)
  );
endmodule

// File: rtl/arq_link_sender_chk.sv
module arq_link_sender_chk #(
  parameter int MAX_WIN = 8,
  parameter int SEQ_W   = 4,
  parameter int LINK_W  = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic [SEQ_W-1:0]  cfgWindow,
  input logic [SEQ_W-1:0]  outstanding,
  input logic              inReady,
  input logic              txValid,
  input logic [LINK_W-1:0] txLink,
  input logic [LINK_W-1:0] originLink,
  input logic              doneValid,
  input logic [SEQ_W-1:0]  doneCount,
  input logic              failValid,
  input logic [SEQ_W-1:0]  failCount
);
  int effWin;
  always_comb begin
    effWin = int'(cfgWindow);
    if (effWin < 1)       effWin = 1;
    if (effWin > MAX_WIN) effWin = MAX_WIN;
  end

  p_window_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    int'(outstanding) <= effWin);

  p_ready_room_r2: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> int'(outstanding) < effWin);

  p_done_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneCount != '0) && (int'(doneCount) <= MAX_WIN));

  p_not_origin_r7: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> txLink != originLink);

  p_fail_count_r8: assert property (@(posedge clk) disable iff (!rstN)
    failValid |-> (failCount == $past(outstanding)) && (failCount != '0));

  p_done_or_fail_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({doneValid, failValid}));
endmodule

bind arq_link_sender arq_link_sender_chk #(.MAX_WIN(MAX_WIN), .SEQ_W(SEQ_W), .LINK_W(LINK_W)) u_chk (
  .clk(clk), .rstN(rstN), .cfgWindow(cfgWindow), .outstanding(outstanding),
  .inReady(inReady), .txValid(txValid), .txLink(txLink), .originLink(originLink),
  .doneValid(doneValid), .doneCount(doneCount), .failValid(failValid), .failCount(failCount)
);

// File: tb/arq_link_sender_tb.sv
module arq_link_sender_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LOGN = 1024;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cfgWindow = 4'd3;
  logic [2:0] cfgRetries = 3'd2;
  logic [7:0] cfgTimeout = 8'd20;
  logic [11:0] routeTable = {3'd3, 3'd5, 3'd2, 3'd1};
  logic [2:0] routeLen = 3'd3;
  logic [2:0] originLink = 3'd2;
  logic       inValid = 1'b0;
  logic [7:0] inData = '0;
  logic       inReady, txValid, txReady;
  logic [3:0] txSeq;
  logic [7:0] txData;
  logic [2:0] txLink;
  logic       ackValid = 1'b0;
  logic [3:0] ackSeq = '0;
  logic       doneValid, failValid;
  logic [3:0] doneCount, failCount;
  logic [2:0] doneLink;

  int nChecks = 0, nFails = 0, cyc = 0;
  int nFire = 0, nAccepted = 0, doneTotal = 0, nDone = 0, nFailEv = 0;
  int fSeq [LOGN]; int fLink [LOGN]; int fData [LOGN]; int fCyc [LOGN];
  int pushData [LOGN];
  logic fireNow, acceptNow;
  int lastFailCount = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  arq_link_sender u_dut (
    .clk(clk), .rstN(rstN), .cfgWindow(cfgWindow), .cfgRetries(cfgRetries),
    .cfgTimeout(cfgTimeout), .routeTable(routeTable), .routeLen(routeLen),
    .originLink(originLink), .inValid(inValid), .inData(inData), .inReady(inReady),
    .txValid(txValid), .txReady(txReady), .txSeq(txSeq), .txData(txData),
    .txLink(txLink), .ackValid(ackValid), .ackSeq(ackSeq),
    .doneValid(doneValid), .doneCount(doneCount), .doneLink(doneLink),
    .failValid(failValid), .failCount(failCount)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int clampWin(input int w);
    if (w < 1) return 1;
    if (w > 8) return 8;
    return w;
  endfunction

  // one clock: sample handshakes before the edge, observe pulses after it
  task automatic step();
    #1;
    fireNow   = txValid && txReady;
    acceptNow = inValid && inReady;
    if (fireNow && nFire < LOGN) begin
      fSeq[nFire] = int'(txSeq); fLink[nFire] = int'(txLink);
      fData[nFire] = int'(txData); fCyc[nFire] = cyc; nFire++;
    end
    if (acceptNow && nAccepted < LOGN) begin
      pushData[nAccepted] = int'(inData); nAccepted++;
    end
    @(negedge clk); #1;
    cyc++;
    if (doneValid) begin doneTotal += int'(doneCount); nDone++; end
    if (failValid) begin nFailEv++; lastFailCount = int'(failCount); end
  endtask

  task automatic doReset();
    inValid = 0; ackValid = 0; txReady = 0;
    rstN = 0;
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    nFire = 0; nAccepted = 0; doneTotal = 0; nDone = 0; nFailEv = 0;
  endtask

  task automatic windowFill(input int w, input int tries);
    cfgWindow = 4'(w);
    doReset();
    txReady = 0; inValid = 1;
    for (int k = 0; k < tries; k++) begin inData = 8'(k); step(); end
    inValid = 0;
    check($sformatf("R2 accepted with cfgWindow=%0d", w), nAccepted, clampWin(w));
    check("R2 inReady low when full", int'(inReady), 0);
  endtask

  task automatic randomRun(input int w, input int cycles);
    int nRx;
    logic pend;
    int maxOut, out;
    cfgWindow = 4'(w); cfgRetries = 3'd7; cfgTimeout = 8'd30;
    routeLen = 3'd4; originLink = 3'd7;
    doReset();
    nRx = 0; pend = 0; maxOut = 0;
    for (int c = 0; c < cycles + 6000; c++) begin
      if (c >= cycles && doneTotal == nAccepted) break;
      inValid  = (c < cycles) && ($urandom_range(9) < 6);
      inData   = 8'($urandom);
      txReady  = ($urandom_range(9) < 7);
      ackValid = pend && ($urandom_range(9) < 7);
      ackSeq   = 4'(nRx - 1);
      if (ackValid) pend = 0;
      nFire = 0;
      step();
      if (fireNow && $urandom_range(3) != 0) begin
        if (fSeq[0] == (nRx % 16)) begin
          check($sformatf("R1 in-order payload #%0d", nRx), fData[0], pushData[nRx]);
          nRx++;
        end
        if (nRx > 0) pend = 1;
      end
      out = nAccepted - doneTotal;
      if (out > maxOut) maxOut = out;
    end
    inValid = 0; ackValid = 0;
    check("R3 all accepted packets acknowledged", doneTotal, nAccepted);
    check("R3 all accepted packets delivered", nRx, nAccepted);
    check("R2 outstanding never above window", int'(maxOut <= clampWin(w)), 1);
    check("R8 no failover exhaustion in random run", nFailEv, 0);
  endtask

  initial begin
    int zeroIdx [8];
    int nz;
    void'($urandom(32'd2024));

    // R10 reset state
    doReset();
    check("R10 txValid after reset", int'(txValid), 0);
    check("R10 inReady after reset", int'(inReady), 1);
    check("R10 doneValid after reset", int'(doneValid), 0);
    check("R10 failValid after reset", int'(failValid), 0);

    // R2 window fill, then R1 numbering and R7 preferred link
    windowFill(3, 6);
    txReady = 1;
    repeat (3) step();
    txReady = 0;
    check("R1 fires after fill", nFire, 3);
    for (int k = 0; k < 3; k++) begin
      check($sformatf("R1 seq of packet %0d", k), fSeq[k], k);
      check($sformatf("R1 data of packet %0d", k), fData[k], k);
      check("R7 first usable link used", fLink[k], 1);
    end

    // R3 cumulative ack of seq 1 frees two
    ackValid = 1; ackSeq = 4'd1; step(); ackValid = 0;
    check("R3 doneValid after ack 1", int'(doneValid), 1);
    check("R3 doneCount after ack 1", int'(doneCount), 2);
    check("R3 doneLink after ack 1", int'(doneLink), 1);
    check("R2 inReady after freeing", int'(inReady), 1);
    // R4 ack beyond window and stale ack are ignored
    ackValid = 1; ackSeq = 4'd7; step(); ackValid = 0;
    check("R4 ack beyond window ignored", int'(doneValid), 0);
    ackValid = 1; ackSeq = 4'd1; step(); ackValid = 0;
    check("R4 stale ack ignored", int'(doneValid), 0);
    ackValid = 1; ackSeq = 4'd2; step(); ackValid = 0;
    check("R4 state unchanged: later ack frees one", int'(doneCount), 1);

    // R2 clamp boundaries
    windowFill(0, 4);
    windowFill(12, 12);

    // R5/R6/R8 retransmission, failover and exhaustion
    cfgWindow = 4'd3; cfgRetries = 3'd2; cfgTimeout = 8'd20;
    routeLen = 3'd3; originLink = 3'd2;
    doReset();
    txReady = 1; inValid = 1;
    inData = 8'h11; step();
    inData = 8'h22; step();
    inValid = 0;
    for (int c = 0; c < 600 && nFailEv == 0; c++) step();
    check("R8 one failure pulse", nFailEv, 1);
    check("R8 failCount", lastFailCount, 2);
    check("R5 total transmissions", nFire, 12);
    nz = 0;
    for (int k = 0; k < nFire; k++) begin
      check("R7 never origin link", int'(fLink[k] != 2), 1);
      if (fSeq[k] == 0 && nz < 8) begin zeroIdx[nz] = k; nz++; end
    end
    check("R6 oldest sent 3 times per link on 2 links", nz, 6);
    for (int k = 0; k < nz && k < 6; k++) begin
      check($sformatf("R6 link of send %0d of oldest", k), fLink[zeroIdx[k]], (k < 3) ? 1 : 5);
      if (zeroIdx[k] + 1 < nFire)
        check("R5 oldest followed by next in order", fSeq[zeroIdx[k] + 1], 1);
      if (k > 0)
        check("R5 resend spacing", fCyc[zeroIdx[k]] - fCyc[zeroIdx[k-1]], 21);
    end
    step();
    check("R8 fail pulse lasts one cycle", int'(failValid), 0);
    check("R8 nothing left to send", int'(txValid), 0);
    check("R8 input open again", int'(inReady), 1);
    nFire = 0;
    inValid = 1; inData = 8'h33; step(); inValid = 0;
    step();
    check("R7 back to preferred link", (nFire > 0) ? fLink[0] : -1, 1);
    txReady = 0;

    // R9 no usable entry
    originLink = 3'd1; routeLen = 3'd1;
    doReset();
    inValid = 1; txReady = 1; step(); inValid = 0;
    check("R9 inReady with origin-only route", int'(inReady), 0);
    check("R9 nothing accepted", nAccepted, 0);
    routeLen = 3'd0; originLink = 3'd7; #1;
    check("R9 inReady with empty route", int'(inReady), 0);
    check("R9 txValid with empty route", int'(txValid), 0);
    txReady = 0;

    // random traffic with a lossy in-order receiver
    randomRun(1, 800);
    randomRun(8, 1500);
    randomRun($urandom_range(7, 2), 1500);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule